// File: doc/BRIEF.md
# Super I/O Configuration Unlock Controller

This block is the device-side configuration front end of a legacy I/O controller on an 8-bit I/O-mapped bus with a 16-bit port address, separate write and read strobes and byte data. Configuration access is guarded by a two-stage entry. First, a four-byte key is written to the fixed port 0x0279, and its last two bytes choose where the configuration ports will decode. Second, a 32-byte pseudo-random sequence is written to that chosen base. Only then does the block enter configuration mode.

In configuration mode the base port holds a register index and base+1 is the data window onto the indexed register. A logical-device-number register banks the per-device activate register. A global permit register gates each device's enable output, and one more global register holds the clock-select and software-suspend bits. A specific value written to the control register leaves configuration mode. The block drives only the enable outputs. The peripherals themselves are elsewhere.

Top module: `sio_cfg_unlock`

## Requirements
- R1: The fourth key byte picks the base. The key 0x86 0x80 0x55 0x55 picks 0x3F0, 0x86 0x80 0x55 0xAA picks 0x3BD, and 0x86 0x80 0xAA 0x55 picks 0x370. A third/fourth pair of 0xAA 0xAA is rejected.
- R2: After a valid key, 32 bytes must be written in order to the base port. The first is 0x6A, and each next byte is {b[0]^b[1], b[7:1]} of the previous one. `cfg_mode` rises in the cycle after the 32nd matching byte is written, and not earlier.
- R3: A wrong key byte or a wrong unlock byte returns the sequencer to idle. A wrong key byte equal to 0x86 counts as a new first key byte. Writes to other ports between key bytes do not disturb the key.
- R4: While `cfg_mode` is 0, writes to the base and base+1 ports change nothing, and every read returns 0xFF.
- R5: In configuration mode a write to the base port sets the index, and reading the base port returns it. Data reads and writes at base+1 act on the indexed register.
- R6: Register 0x07 holds the logical device number: 0 floppy, 1 COM1, 2 COM2, 3 parallel, 4 IR. Bit 0 of register 0x30 is the activate bit of the selected device. With any other device number, register 0x30 writes nothing and reads 0xFF.
- R7: Register 0x23 holds permit bits, with bit i permitting device i. Bits 7:5 read as 0 and ignore writes.
- R8: `dev_en[i]` is 1 exactly when device i's activate bit and permit bit are both 1. It updates in the cycle after the data write.
- R9: Register 0x24 has bit 1 as `clk_sel` (0 means 24 MHz) and bit 0 as `suspend`. It reads back with bits 7:2 as 0.
- R10: Writing 0x02 to register 0x02 leaves configuration mode. Any other value written there does nothing. Register 0x02 and all unimplemented indexes read 0xFF.
- R11: A synchronous active-high reset clears `cfg_mode`, the index, the device number, all activate bits and register 0x23. It sets register 0x24 to 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0xFF when nothing decodes |
| cfg_mode | output | 1 | Configuration mode active |
| dev_en | output | 5 | Device enables: floppy, COM1, COM2, parallel, IR (bit 0 first) |
| clk_sel | output | 1 | Input clock select, 0 = 24 MHz |
| suspend | output | 1 | Software suspend flag |

## Verification
Entry is tried with all three valid base keys and with the invalid 0xAA 0xAA pair. A key containing a repeated 0x86 shows that the restart path works, and a key split by an unrelated write shows that stray traffic does not break the key. An unlock sequence broken at byte 11, with the remaining bytes still sent, separates an order-checking sequencer from one that only counts bytes. Register traffic uses partial permit masks against full activate sets, and an out-of-range device number, so that the AND gating and the banking can each fail on their own. A near-miss exit value, and locked-mode writes after exit, tell a full exit apart from a partial one.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_UNLOCK, ST_CFG
  } seq_state_e;

  localparam logic [7:0] KEY_B1 = 8'h86;
  localparam logic [7:0] KEY_B2 = 8'h80;
  localparam logic [7:0] KEY_LO = 8'h55;
  localparam logic [7:0] KEY_HI = 8'hAA;

  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_PERMIT = 8'h23;
  localparam logic [7:0] IDX_CLK    = 8'h24;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] EXIT_CODE  = 8'h02;

  // next byte of the unlock stream: shift right, feedback of the two low bits
  function automatic logic [7:0] unlock_next(input logic [7:0] b);
    return {b[0] ^ b[1], b[7:1]};
  endfunction

  // {valid, base} from key bytes three and four
  function automatic logic [16:0] base_decode(input logic [7:0] k3, input logic [7:0] k4);
    logic [16:0] r;
    r = '0;
    if (k3 == KEY_LO && k4 == KEY_LO)      r = {1'b1, 16'h03F0};
    else if (k3 == KEY_LO && k4 == KEY_HI) r = {1'b1, 16'h03BD};
    else if (k3 == KEY_HI && k4 == KEY_LO) r = {1'b1, 16'h0370};
    return r;
  endfunction

endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] KEY_PORT    = 16'h0279,
  parameter int          UNLOCK_LEN  = 32,
  parameter logic [7:0]  UNLOCK_SEED = 8'h6A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        exit_req,
  output logic        cfg_mode,
  output logic [15:0] base
);
  localparam int CW = $clog2(UNLOCK_LEN);
  localparam logic [CW-1:0] LAST = CW'(UNLOCK_LEN - 1);

  seq_state_e  state_q;
  logic [7:0]  third_q;
  logic [7:0]  exp_q;
  logic [CW-1:0] cnt_q;
  logic [15:0] base_q;

  logic key_wr, base_wr, key_miss, unl_miss, miss_evt, last_match;
  logic [16:0] dec;
  seq_state_e restart_st;

  assign key_wr     = wr && (addr == KEY_PORT);
  assign base_wr    = wr && (addr == base_q);
  assign dec        = base_decode(third_q, wdata);
  assign restart_st = (wdata == KEY_B1) ? ST_K1 : ST_IDLE;

  assign key_miss = key_wr && (
      (state_q == ST_K1 && wdata != KEY_B2) ||
      (state_q == ST_K2 && !(wdata == KEY_LO || wdata == KEY_HI)) ||
      (state_q == ST_K3 && !dec[16]));
  assign unl_miss   = base_wr && (state_q == ST_UNLOCK) && (wdata != exp_q);
  assign miss_evt   = key_miss || unl_miss;
  assign last_match = base_wr && (state_q == ST_UNLOCK) && (wdata == exp_q) && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      third_q <= '0;
      exp_q   <= UNLOCK_SEED;
      cnt_q   <= '0;
      base_q  <= 16'h03F0;
    end else begin
      case (state_q)
        ST_IDLE: if (key_wr && wdata == KEY_B1) state_q <= ST_K1;
        ST_K1:   if (key_wr) state_q <= (wdata == KEY_B2) ? ST_K2 : restart_st;
        ST_K2:   if (key_wr) begin
          if (wdata == KEY_LO || wdata == KEY_HI) begin
            state_q <= ST_K3;
            third_q <= wdata;
          end else begin
            state_q <= restart_st;
          end
        end
        ST_K3:   if (key_wr) begin
          if (dec[16]) begin
            state_q <= ST_UNLOCK;
            base_q  <= dec[15:0];
            cnt_q   <= '0;
            exp_q   <= UNLOCK_SEED;
          end else begin
            state_q <= restart_st;
          end
        end
        ST_UNLOCK: if (base_wr) begin
          if (wdata != exp_q) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == LAST) begin
            state_q <= ST_CFG;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            exp_q <= unlock_next(exp_q);
          end
        end
        ST_CFG:  if (exit_req) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_mode = (state_q == ST_CFG);
  assign base     = base_q;

  // R2: configuration mode only follows a matching final unlock byte
  a_r2_enter_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(last_match));

  // R3: any miss drops back to idle or to the restarted first key byte
  a_r3_miss_to_idle: assert property (@(posedge clk) disable iff (rst)
    miss_evt |=> (state_q == ST_IDLE || state_q == ST_K1));

  // R1: the decoded base is always one of the three legal ones
  a_r1_base_legal: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |-> (base_q == 16'h03F0 || base_q == 16'h03BD || base_q == 16'h0370));

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic [15:0]        base,
  input  logic               wr,
  input  logic               rd,
  input  logic [15:0]        addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [NUM_DEV-1:0] dev_en,
  output logic               clk_sel,
  output logic               suspend,
  output logic               exit_req
);
  logic [7:0]         idx_q, ldn_q;
  logic [NUM_DEV-1:0] permit_q, act_q;
  logic               clk_sel_q, susp_q;

  logic [15:0] data_addr;
  logic idx_wr, dat_wr, idx_rd, dat_rd, ldn_valid, act_sel;

  assign data_addr = base + 16'd1;
  assign idx_wr    = cfg_mode && wr && (addr == base);
  assign dat_wr    = cfg_mode && wr && (addr == data_addr);
  assign idx_rd    = cfg_mode && rd && (addr == base);
  assign dat_rd    = cfg_mode && rd && (addr == data_addr);
  assign ldn_valid = (ldn_q < 8'(NUM_DEV));
  assign exit_req  = dat_wr && (idx_q == IDX_CTRL) && (wdata == EXIT_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      ldn_q     <= '0;
      permit_q  <= '0;
      clk_sel_q <= 1'b1;
      susp_q    <= 1'b1;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (dat_wr) begin
        case (idx_q)
          IDX_LDN:    ldn_q    <= wdata;
          IDX_PERMIT: permit_q <= wdata[NUM_DEV-1:0];
          IDX_CLK:    {clk_sel_q, susp_q} <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // one activate bit per logical device, written through the bank window
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    always_ff @(posedge clk) begin
      if (rst) act_q[g] <= 1'b0;
      else if (dat_wr && idx_q == IDX_ACT && ldn_q == 8'(g)) act_q[g] <= wdata[0];
    end
    assign dev_en[g] = act_q[g] & permit_q[g];
  end

  always_comb begin
    act_sel = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldn_q == 8'(i)) act_sel = act_q[i];
  end

  always_comb begin
    rdata = 8'hFF;
    if (idx_rd) begin
      rdata = idx_q;
    end else if (dat_rd) begin
      case (idx_q)
        IDX_LDN:    rdata = ldn_q;
        IDX_PERMIT: rdata = 8'(permit_q);
        IDX_CLK:    rdata = {6'b0, clk_sel_q, susp_q};
        IDX_ACT:    rdata = ldn_valid ? {7'b0, act_sel} : 8'hFF;
        default:    rdata = 8'hFF;
      endcase
    end
  end

  assign clk_sel = clk_sel_q;
  assign suspend = susp_q;

  // R4: locked mode leaves every configuration register untouched
  a_r4_locked_no_change: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ($stable(act_q) && $stable(permit_q) && $stable(idx_q) && $stable(ldn_q)));

  // R6: an activate bit only moves while a valid device is selected
  a_r6_act_bank_valid: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> ($past(ldn_q) < 8'(NUM_DEV)));

  // R7: permit register never shows reserved bits
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && idx_q == IDX_PERMIT) |-> (rdata[7:5] == 3'b000));

endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] KEY_PORT    = 16'h0279,
  parameter int          UNLOCK_LEN  = 32,
  parameter logic [7:0]  UNLOCK_SEED = 8'h6A,
  parameter int          NUM_DEV     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               cfg_mode,
  output logic [NUM_DEV-1:0] dev_en,
  output logic               clk_sel,
  output logic               suspend
);
  logic [15:0] base;
  logic        exit_req;

  sio_key_seq #(
    .KEY_PORT(KEY_PORT), .UNLOCK_LEN(UNLOCK_LEN), .UNLOCK_SEED(UNLOCK_SEED)
  ) u_seq (
    .clk(clk), .rst(rst), .wr(io_wr), .addr(io_addr), .wdata(io_wdata),
    .exit_req(exit_req), .cfg_mode(cfg_mode), .base(base)
  );

  sio_cfg_regs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .base(base),
    .wr(io_wr), .rd(io_rd), .addr(io_addr), .wdata(io_wdata),
    .rdata(io_rdata), .dev_en(dev_en), .clk_sel(clk_sel),
    .suspend(suspend), .exit_req(exit_req)
  );

  // R10: the exit command always drops configuration mode next cycle
  a_r10_exit_drops: assert property (@(posedge clk) disable iff (rst)
    exit_req |=> !cfg_mode);

  // R4: nothing but 0xFF is visible while locked
  a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |-> (io_rdata == 8'hFF));

  // R9: clock and suspend bits hold while locked
  a_r9_locked_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ($stable(clk_sel) && $stable(suspend) && $stable(dev_en)));

endmodule

// File: tb/tb_sio_cfg_unlock.sv
`timescale 1ns/1ps
module tb_sio_cfg_unlock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cfg_mode, clk_sel, suspend;
  logic [4:0]  dev_en;

  int checks = 0, errors = 0;
  bit done = 0;
  int useq[32];

  // behavioural reference state
  int m_mode, m_kpos, m_k3, m_base, m_upos, m_idx, m_ldn, m_permit, m_act, m_clk, m_sus;

  always #2 clk = ~clk;

  sio_cfg_unlock dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
    .dev_en(dev_en), .clk_sel(clk_sel), .suspend(suspend)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int key_restart(int d);
    return (d == 'h86) ? 1 : 0;
  endfunction

  function automatic int model_rdata();
    if (m_mode != 2 || !io_rd) return 'hFF;
    if (io_addr == m_base) return m_idx;
    if (io_addr != m_base + 1) return 'hFF;
    case (m_idx)
      'h07: return m_ldn;
      'h23: return m_permit;
      'h24: return m_clk * 2 + m_sus;
      'h30: return (m_ldn < 5) ? ((m_act >> m_ldn) & 1) : 'hFF;
      default: return 'hFF;
    endcase
  endfunction

  task automatic model_step();
    int d;
    d = io_wdata;
    if (rst) begin
      m_mode = 0; m_kpos = 0; m_k3 = 0; m_base = 'h3F0; m_upos = 0;
      m_idx = 0; m_ldn = 0; m_permit = 0; m_act = 0; m_clk = 1; m_sus = 1;
    end else if (io_wr) begin
      if (m_mode == 2) begin
        if (io_addr == m_base) m_idx = d;
        else if (io_addr == m_base + 1) begin
          case (m_idx)
            'h07: m_ldn = d;
            'h23: m_permit = d % 32;
            'h24: begin m_clk = (d / 2) % 2; m_sus = d % 2; end
            'h30: if (m_ldn < 5) m_act = (m_act & ~(1 << m_ldn)) | ((d % 2) << m_ldn);
            'h02: if (d == 2) begin m_mode = 0; m_kpos = 0; end
            default: ;
          endcase
        end
      end else if (m_mode == 1) begin
        if (io_addr == m_base) begin
          if (d == useq[m_upos]) begin
            m_upos++;
            if (m_upos == 32) m_mode = 2;
          end else begin
            m_mode = 0; m_kpos = 0;
          end
        end
      end else if (io_addr == 'h279) begin
        case (m_kpos)
          0: m_kpos = key_restart(d);
          1: m_kpos = (d == 'h80) ? 2 : key_restart(d);
          2: if (d == 'h55 || d == 'hAA) begin m_k3 = d; m_kpos = 3; end
             else m_kpos = key_restart(d);
          default: begin
            if (m_k3 == 'h55 && d == 'h55) begin m_base = 'h3F0; m_mode = 1; end
            else if (m_k3 == 'h55 && d == 'hAA) begin m_base = 'h3BD; m_mode = 1; end
            else if (m_k3 == 'hAA && d == 'h55) begin m_base = 'h370; m_mode = 1; end
            if (m_mode == 1) begin m_upos = 0; m_kpos = 0; end
            else m_kpos = key_restart(d);
          end
        endcase
      end
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    model_step();
    #1;
    if (!done) begin
      check("R2 cfg_mode vs model", cfg_mode, (m_mode == 2) ? 1 : 0);
      check("R5 io_rdata vs model", io_rdata, model_rdata());
      check("R8 dev_en vs model", dev_en, m_act & m_permit);
      check("R9 clk_sel/suspend vs model", {clk_sel, suspend}, m_clk * 2 + m_sus);
    end
  end

  task automatic bwrite(int a, int d);
    @(negedge clk);
    io_wr = 1'b1; io_rd = 1'b0; io_addr = 16'(a); io_wdata = 8'(d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bread(int a, int exp, string tag);
    @(negedge clk);
    io_rd = 1'b1; io_wr = 1'b0; io_addr = 16'(a);
    #1 check(tag, io_rdata, exp);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic send_key(int k3, int k4);
    bwrite('h279, 'h86); bwrite('h279, 'h80); bwrite('h279, k3); bwrite('h279, k4);
  endtask

  task automatic send_unlock(int base, int upto);
    for (int i = 0; i < upto; i++) bwrite(base, useq[i]);
  endtask

  task automatic creg_wr(int base, int idx, int val);
    bwrite(base, idx); bwrite(base + 1, val);
  endtask

  task automatic creg_rd(int base, int idx, int exp, string tag);
    bwrite(base, idx); bread(base + 1, exp, tag);
  endtask

  initial begin
    int v;
    v = 'h6A;
    for (int i = 0; i < 32; i++) begin
      useq[i] = v;
      v = (v >> 1) | ((((v >> 1) ^ v) & 1) << 7);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    check("R11 cfg_mode after reset", cfg_mode, 0);
    check("R11 dev_en after reset", dev_en, 0);
    check("R11 clk_sel after reset", clk_sel, 1);
    check("R11 suspend after reset", suspend, 1);

    // R4: locked accesses
    bwrite('h3F0, 'h24); bwrite('h3F1, 'h00);
    bread('h3F0, 'hFF, "R4 locked index read");
    check("R4 locked write ignored", {clk_sel, suspend}, 3);

    // R1/R2: base 0x3F0, entry only after all 32 bytes
    send_key('h55, 'h55);
    send_unlock('h3F0, 31);
    check("R2 not yet in cfg after 31 bytes", cfg_mode, 0);
    bwrite('h3F0, useq[31]);
    check("R2 cfg after 32 bytes", cfg_mode, 1);

    // R5: index readback
    bwrite('h3F0, 'h5A);
    bread('h3F0, 'h5A, "R5 index readback");
    // R7: permit with reserved bits
    creg_wr('h3F0, 'h23, 'hFF);
    creg_rd('h3F0, 'h23, 'h1F, "R7 permit reserved bits");
    creg_wr('h3F0, 'h23, 'h05);
    // R6/R8: activate all five devices
    for (int d = 0; d < 5; d++) begin
      creg_wr('h3F0, 'h07, d);
      creg_wr('h3F0, 'h30, 'h01);
    end
    check("R8 dev_en = act & permit", dev_en, 'h05);
    creg_wr('h3F0, 'h23, 'h1A);
    check("R8 dev_en after permit change", dev_en, 'h1A);
    creg_wr('h3F0, 'h07, 'h03);
    creg_wr('h3F0, 'h30, 'h00);
    check("R6 banked clear of device 3", dev_en, 'h12);
    creg_rd('h3F0, 'h30, 'h00, "R6 device 3 activate read");
    creg_wr('h3F0, 'h07, 'h01);
    creg_rd('h3F0, 'h30, 'h01, "R6 device 1 activate read");
    creg_wr('h3F0, 'h07, 'h07);
    creg_wr('h3F0, 'h30, 'h00);
    creg_rd('h3F0, 'h30, 'hFF, "R6 invalid device reads FF");
    check("R6 invalid device writes nothing", dev_en, 'h12);
    creg_rd('h3F0, 'h07, 'h07, "R6 device number readback");
    // R9
    creg_wr('h3F0, 'h24, 'hFE);
    check("R9 clk_sel", clk_sel, 1);
    check("R9 suspend", suspend, 0);
    creg_rd('h3F0, 'h24, 'h02, "R9 readback");
    creg_wr('h3F0, 'h24, 'h00);
    check("R9 both cleared", {clk_sel, suspend}, 0);
    // R10
    creg_rd('h3F0, 'h02, 'hFF, "R10 control reads FF");
    creg_rd('h3F0, 'h41, 'hFF, "R10 unimplemented reads FF");
    creg_wr('h3F0, 'h02, 'h03);
    check("R10 near-miss exit ignored", cfg_mode, 1);
    creg_wr('h3F0, 'h02, 'h02);
    check("R10 exit", cfg_mode, 0);
    creg_wr('h3F0, 'h23, 'h00);
    check("R4 write after exit ignored", dev_en, 'h12);

    // R3: repeated 0x86 and stray write inside the key, base 0x3BD
    bwrite('h279, 'h86); bwrite('h279, 'h86); bwrite('h279, 'h80);
    bwrite('h0080, 'h00);
    bwrite('h279, 'h55); bwrite('h279, 'hAA);
    send_unlock('h3BD, 32);
    check("R3 restart and stray write tolerated", cfg_mode, 1);
    bwrite('h3BD, 'h24);
    bread('h3BD, 'h24, "R1 base 0x3BD index");
    bread('h3F0, 'hFF, "R1 old base not decoded");
    creg_wr('h3BD, 'h02, 'h02);

    // R1: invalid pair, then R3 broken unlock at 0x370
    send_key('hAA, 'hAA);
    send_unlock('h370, 32);
    check("R1 AA AA rejected", cfg_mode, 0);
    send_key('hAA, 'h55);
    send_unlock('h370, 10);
    bwrite('h370, 'h00);
    for (int i = 11; i < 32; i++) bwrite('h370, useq[i]);
    check("R3 broken unlock stays locked", cfg_mode, 0);
    send_key('hAA, 'h55);
    send_unlock('h370, 32);
    check("R1 base 0x370 entry", cfg_mode, 1);
    creg_rd('h370, 'h07, 'h07, "R5 data port at 0x371");

    // R11: reset from configuration mode
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R11 cfg cleared by reset", cfg_mode, 0);
    check("R11 dev_en cleared by reset", dev_en, 0);
    check("R11 reg 0x24 set by reset", {clk_sel, suspend}, 3);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule